// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block sequences the two gate-drive enables of one synchronous buck phase: the high-side switch enable and the low-side switch enable. A controller supplies a three-level PWM command and a three-level enable, both already decoded into two-bit level codes. The analog front end supplies a supply-good flag, one comparator flag per gate saying that the gate has fallen below its turn-on threshold, and a zero-current-crossing flag. All of these inputs are asynchronous. Each one passes through a two-stage synchronizer before the state machine uses it.

Dead time is adaptive. Before one switch is turned on, the sequencer turns the other switch off and waits until that gate's own threshold feedback confirms it is off. A mid-level PWM command starts a diode-emulation sequence:

- the high side is turned off and the low side is turned on after the adaptive wait;
- the zero-cross flag is ignored for a blanking window;
- the low side is turned off once the inductor current reaches zero, and both switches then stay off.

If awaited feedback never arrives, a timeout parks both outputs low and raises a fault. The fault holds until the enable is withdrawn.

States are named as follows:
- `ST_OFF`: idle, lockout or disabled.
- `ST_LS_OFF_WAIT`: waiting for the low-side gate to discharge before a high-side turn-on.
- `ST_HS_ON`: high side conducting.
- `ST_HS_OFF_WAIT`: waiting for the high-side gate to discharge.
- `ST_LS_ON`: low side conducting.
- `ST_DE_BLANK`, `ST_DE_WATCH`, `ST_DE_IDLE`: the three diode-emulation phases (blanking, zero-cross watch, both off after zero crossing).
- `ST_FAULT`: feedback timeout.

Transitions are named as follows:
- start (`ST_OFF` to a wait state);
- confirm (wait state to a conducting state);
- handover (conducting state to the opposite wait state);
- blank-expire (`ST_DE_BLANK` to `ST_DE_WATCH`);
- zero-cross (`ST_DE_WATCH` to `ST_DE_IDLE`);
- re-command (any diode-emulation state back to complementary switching);
- timeout (wait state to `ST_FAULT`);
- withdraw (supply loss or enable not high, to `ST_OFF`);
- clear (`ST_FAULT` to `ST_OFF` when the enable is not high).

Top module: `buck_gate_seq`

## Requirements
- R1: While the synchronized supply-good flag is 0, both gate enables are 0 from the next cycle onward. When supply-good returns, normal sequencing resumes through the start transition.
- R2: An enable code other than high (00 = low, 01 = mid, 11 = unused) drives both gate enables to 0. Returning the enable to high (10) restarts sequencing.
- R3: A high PWM command (10) drops the low-side enable first. The high-side enable rises only on the cycle after the synchronized low-side below-threshold flag has been seen while the low side is off.
- R4: A low PWM command (00) drops the high-side enable first. The low-side enable rises only on the cycle after the synchronized high-side below-threshold flag has been seen while the high side is off.
- R5: A mid PWM command (01, and the unused code 11) drops the high-side enable. After the same adaptive wait as R4, it raises the low-side enable. A mid command that arrives while the low side already conducts keeps the low side on.
- R6: In diode emulation, the zero-cross flag is ignored for BLANK_CYC cycles, counted from the cycle the low side rises or is kept on in mid mode. The earliest zero-cross turn-off therefore lands BLANK_CYC+1 cycles after that point.
- R7: After blanking, the low side stays on until the synchronized zero-cross flag is 1. It then turns off on the next cycle, and both enables stay 0 while the mid command persists.
- R8: A high or low PWM command in any diode-emulation state discards the pending zero-cross state and resumes complementary switching, using the sequencing of R3 or R4.
- R9: If the awaited below-threshold flag stays 0 for TIMEOUT_CYC cycles in a wait state, both enables go to 0 and the fault output goes to 1. The fault holds until the enable code leaves high.
- R10: The two gate enables are never 1 in the same cycle.
- R11: Each input passes through two synchronizer flops. A change at an input first affects the outputs at the third rising clock edge after it.
- R12: During reset, both gate enables and the fault output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_lvl | input | 2 | PWM command level code: 00 low, 01 mid, 10 high, 11 treated as mid |
| en_lvl | input | 2 | Enable level code; only 10 enables |
| supply_ok | input | 1 | Supply above its start threshold |
| hs_below | input | 1 | High-side gate-to-switch-node voltage below threshold |
| ls_below | input | 1 | Low-side gate voltage below threshold |
| zc_det | input | 1 | Inductor current has crossed zero |
| hs_on | output | 1 | High-side gate-drive enable |
| ls_on | output | 1 | Low-side gate-drive enable |
| fault | output | 1 | Feedback-timeout fault |

## Verification
The bench builds the sequencer with BLANK_CYC = 6 and TIMEOUT_CYC = 10. At these values the blanking edge and the feedback-timeout edge fall within a few dozen cycles, so each can be checked on the exact cycle where it lands, as can the cycle just before it. The defaults (88 and 256 cycles) would only stretch the run without adding new orderings. The bench's gate model returns each below-threshold flag as the inverse of the matching enable, so every adaptive dead time passes through the real synchronizer path. A stuck-flag control then withholds that feedback to reach the timeout.

// File: rtl/gseq_pkg.sv
`timescale 1ns/1ps
package gseq_pkg;

    localparam logic [1:0] LVL_LOW  = 2'b00;
    localparam logic [1:0] LVL_MID  = 2'b01;
    localparam logic [1:0] LVL_HIGH = 2'b10;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_LS_OFF_WAIT,
        ST_HS_ON,
        ST_HS_OFF_WAIT,
        ST_LS_ON,
        ST_DE_BLANK,
        ST_DE_WATCH,
        ST_DE_IDLE,
        ST_FAULT
    } gseq_state_t;

endpackage

// File: rtl/gseq_sync.sv
`timescale 1ns/1ps
// Multi-bit flop-chain synchronizer; each bit is independent.
module gseq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gseq_cnt.sv
`timescale 1ns/1ps
// Saturating cycle counter, cleared on every state change.
module gseq_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          q <= '0;
        else if (clr)        q <= '0;
        else if (q != '1)    q <= q + 1'b1;
    end
endmodule

// File: rtl/gseq_fsm.sv
`timescale 1ns/1ps
module gseq_fsm
    import gseq_pkg::*;
#(
    parameter int BLANK_CYC   = 88,
    parameter int TIMEOUT_CYC = 256,
    parameter int CW          = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ok_s,
    input  logic [1:0]    en_s,
    input  logic [1:0]    pwm_s,
    input  logic          hs_below_s,
    input  logic          ls_below_s,
    input  logic          zc_s,
    input  logic [CW-1:0] cnt_q,
    output logic          cnt_clr,
    output logic          hs_on,
    output logic          ls_on,
    output logic          fault
);
    localparam logic [CW-1:0] BLANK_LAST = CW'(BLANK_CYC - 1);
    localparam logic [CW-1:0] WAIT_LAST  = CW'(TIMEOUT_CYC - 1);

    gseq_state_t state_q, state_d;

    logic en_on, pwm_hi, pwm_lo, blank_done, wait_expired;

    always_comb begin
        en_on        = (en_s == LVL_HIGH);
        pwm_hi       = (pwm_s == LVL_HIGH);
        pwm_lo       = (pwm_s == LVL_LOW);
        blank_done   = (cnt_q == BLANK_LAST);
        wait_expired = (cnt_q == WAIT_LAST);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (state_q == ST_FAULT) begin
            if (!en_on) state_d = ST_OFF;                       // clear
        end else if (!ok_s || !en_on) begin
            state_d = ST_OFF;                                   // withdraw
        end else begin
            unique case (state_q)
                ST_OFF:
                    state_d = pwm_hi ? ST_LS_OFF_WAIT : ST_HS_OFF_WAIT;   // start
                ST_LS_OFF_WAIT: begin
                    if (!pwm_hi)           state_d = ST_HS_OFF_WAIT;
                    else if (ls_below_s)   state_d = ST_HS_ON;            // confirm
                    else if (wait_expired) state_d = ST_FAULT;            // timeout
                end
                ST_HS_ON:
                    if (!pwm_hi) state_d = ST_HS_OFF_WAIT;                // handover
                ST_HS_OFF_WAIT: begin
                    if (pwm_hi)            state_d = ST_LS_OFF_WAIT;
                    else if (hs_below_s)   state_d = pwm_lo ? ST_LS_ON : ST_DE_BLANK; // confirm
                    else if (wait_expired) state_d = ST_FAULT;            // timeout
                end
                ST_LS_ON: begin
                    if (pwm_hi)       state_d = ST_LS_OFF_WAIT;           // handover
                    else if (!pwm_lo) state_d = ST_DE_BLANK;
                end
                ST_DE_BLANK: begin
                    if (pwm_hi)          state_d = ST_LS_OFF_WAIT;        // re-command
                    else if (pwm_lo)     state_d = ST_LS_ON;              // re-command
                    else if (blank_done) state_d = ST_DE_WATCH;           // blank-expire
                end
                ST_DE_WATCH: begin
                    if (pwm_hi)      state_d = ST_LS_OFF_WAIT;            // re-command
                    else if (pwm_lo) state_d = ST_LS_ON;                  // re-command
                    else if (zc_s)   state_d = ST_DE_IDLE;                // zero-cross
                end
                ST_DE_IDLE: begin
                    if (pwm_hi)      state_d = ST_LS_OFF_WAIT;            // re-command
                    else if (pwm_lo) state_d = ST_HS_OFF_WAIT;            // re-command
                end
                ST_FAULT:
                    state_d = ST_FAULT;
                default:
                    state_d = ST_OFF;
            endcase
        end
    end

    assign cnt_clr = (state_d != state_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // registered outputs decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_on <= 1'b0;
            ls_on <= 1'b0;
            fault <= 1'b0;
        end else begin
            hs_on <= (state_d == ST_HS_ON);
            ls_on <= (state_d == ST_LS_ON) || (state_d == ST_DE_BLANK)
                  || (state_d == ST_DE_WATCH);
            fault <= (state_d == ST_FAULT);
        end
    end
endmodule

// File: rtl/buck_gate_seq.sv
`timescale 1ns/1ps
module buck_gate_seq #(
    parameter int BLANK_CYC   = 88,
    parameter int TIMEOUT_CYC = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwm_lvl,
    input  logic [1:0] en_lvl,
    input  logic       supply_ok,
    input  logic       hs_below,
    input  logic       ls_below,
    input  logic       zc_det,
    output logic       hs_on,
    output logic       ls_on,
    output logic       fault
);
    localparam int CNT_MAX = (BLANK_CYC > TIMEOUT_CYC) ? BLANK_CYC : TIMEOUT_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int SW      = 8;

    logic [SW-1:0] raw_in, syn_in;
    logic [1:0]    pwm_s, en_s;
    logic          ok_s, hs_below_s, ls_below_s, zc_s;
    logic          cnt_clr;
    logic [CW-1:0] cnt_q;

    assign raw_in = {pwm_lvl, en_lvl, supply_ok, hs_below, ls_below, zc_det};

    gseq_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    assign {pwm_s, en_s, ok_s, hs_below_s, ls_below_s, zc_s} = syn_in;

    gseq_cnt #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .q     (cnt_q)
    );

    gseq_fsm #(
        .BLANK_CYC   (BLANK_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .CW          (CW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ok_s       (ok_s),
        .en_s       (en_s),
        .pwm_s      (pwm_s),
        .hs_below_s (hs_below_s),
        .ls_below_s (ls_below_s),
        .zc_s       (zc_s),
        .cnt_q      (cnt_q),
        .cnt_clr    (cnt_clr),
        .hs_on      (hs_on),
        .ls_on      (ls_on),
        .fault      (fault)
    );
endmodule

// File: rtl/gseq_chk.sv
`timescale 1ns/1ps
module gseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ok_s,
    input logic [1:0] en_s,
    input logic       hs_below_s,
    input logic       ls_below_s,
    input logic       hs_on,
    input logic       ls_on,
    input logic       fault
);
    p_lockout_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_s |=> (!hs_on && !ls_on));

    p_disable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s != 2'b10) |=> (!hs_on && !ls_on));

    p_hs_after_ls_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> ($past(ls_below_s) && !$past(ls_on)));

    p_ls_after_hs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_on) |-> ($past(hs_below_s) && !$past(hs_on)));

    p_fault_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!hs_on && !ls_on));
endmodule

bind buck_gate_seq gseq_chk u_gseq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ok_s       (ok_s),
    .en_s       (en_s),
    .hs_below_s (hs_below_s),
    .ls_below_s (ls_below_s),
    .hs_on      (hs_on),
    .ls_on      (ls_on),
    .fault      (fault)
);

// File: tb/test_buck_gate_seq.sv
`timescale 1ns/1ps
module test_buck_gate_seq;
    localparam int BLANK = 6;
    localparam int TMO   = 10;

    typedef struct {
        int unsigned due;
        bit          hs, ls, flt;
        string       tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pwm_lvl = 2'b00, en_lvl = 2'b00;
    logic       supply_ok = 1'b0, zc_det = 1'b0, stuck_ls = 1'b0;
    logic       hs_below, ls_below, hs_on, ls_on, fault;

    int unsigned cyc = 0;
    int          n_chk = 0, n_bad = 0, n_overlap = 0;
    exp_t        sb[$];

    always #2 clk = ~clk;   // 250 MHz

    // gate model: each below-threshold flag mirrors its own enable
    assign hs_below = !hs_on;
    assign ls_below = !ls_on && !stuck_ls;

    buck_gate_seq #(.BLANK_CYC(BLANK), .TIMEOUT_CYC(TMO)) i_buck_gate_seq (
        .clk(clk), .rst_n(rst_n), .pwm_lvl(pwm_lvl), .en_lvl(en_lvl),
        .supply_ok(supply_ok), .hs_below(hs_below), .ls_below(ls_below),
        .zc_det(zc_det), .hs_on(hs_on), .ls_on(ls_on), .fault(fault)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic cmp(input bit h, input bit l, input bit f, input string tag);
        n_chk++;
        if ({hs_on, ls_on, fault} !== {h, l, f}) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: hs/ls/fault = %b%b%b expected %b%b%b",
                     tag, cyc, hs_on, ls_on, fault, h, l, f);
        end
    endtask

    // driver side: push an expectation d cycles ahead, kept sorted by due cycle
    task automatic expect_at(input int d, input bit h, input bit l, input bit f,
                             input string tag);
        exp_t it;
        int   pos;
        it.due = cyc + d; it.hs = h; it.ls = l; it.flt = f; it.tag = tag;
        pos = sb.size();
        for (int i = 0; i < sb.size(); i++) begin
            if (sb[i].due > it.due) begin pos = i; break; end
        end
        sb.insert(pos, it);
    endtask

    // monitor: compare due items away from the active edge
    always @(negedge clk) begin
        if (rst_n && hs_on && ls_on) n_overlap++;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t it;
            it = sb.pop_front();
            cmp(it.hs, it.ls, it.flt, it.tag);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
        summary();
        $finish;
    end

    initial begin
        step(3);
        cmp(0, 0, 0, "R12 reset state");
        rst_n = 1'b1;
        step(2);

        // R1: enabled and commanded high, but supply not good
        en_lvl = 2'b10; pwm_lvl = 2'b10;
        expect_at(6, 0, 0, 0, "R1 lockout holds outputs low");
        step(7);

        // supply good: start, then confirm on low-side feedback
        supply_ok = 1'b1;
        expect_at(2, 0, 0, 0, "R11 no response before third edge");
        expect_at(3, 0, 0, 0, "R3 low side confirmed off first");
        expect_at(4, 1, 0, 0, "R3 high side on after start");
        step(6);

        // R4: high to low handover with adaptive dead time
        pwm_lvl = 2'b00;
        expect_at(3, 0, 0, 0, "R4 high side dropped");
        expect_at(5, 0, 0, 0, "R4 dead time while feedback syncs");
        expect_at(6, 0, 1, 0, "R4 low side on");
        step(8);

        // R3: low to high handover
        pwm_lvl = 2'b10;
        expect_at(3, 0, 0, 0, "R3 low side dropped");
        expect_at(5, 0, 0, 0, "R3 dead time while feedback syncs");
        expect_at(6, 1, 0, 0, "R3 high side on");
        step(8);

        // R5/R6/R7: mid from high side, zero cross already asserted
        pwm_lvl = 2'b01; zc_det = 1'b1;
        expect_at(3,  0, 0, 0, "R5 high side dropped on mid");
        expect_at(6,  0, 1, 0, "R5 low side on after adaptive wait");
        expect_at(12, 0, 1, 0, "R6 zero cross ignored during blanking");
        expect_at(13, 0, 0, 0, "R7 zero-cross turn-off after blanking");
        expect_at(16, 0, 0, 0, "R7 both stay low");
        step(17);

        // R8: low command from idle diode emulation
        zc_det = 1'b0; pwm_lvl = 2'b00;
        expect_at(3, 0, 0, 0, "R8 re-command passes the high-side wait");
        expect_at(4, 0, 1, 0, "R8 low side on after new low command");
        step(6);

        // R5/R7: unused code 11 acts as mid; low side held without zero cross
        pwm_lvl = 2'b11;
        expect_at(3,  0, 1, 0, "R5 code 11 keeps low side on as mid");
        expect_at(14, 0, 1, 0, "R7 low side held while no zero cross");
        step(15);
        zc_det = 1'b1;
        expect_at(2, 0, 1, 0, "R11 zero cross not seen before third edge");
        expect_at(3, 0, 0, 0, "R7 low side off on zero cross");
        step(5);

        // R8: high command while watching for zero cross
        zc_det = 1'b0; pwm_lvl = 2'b00;
        step(6);
        pwm_lvl = 2'b01;
        step(12);
        pwm_lvl = 2'b10;
        expect_at(3, 0, 0, 0, "R8 pending zero-cross state dropped");
        expect_at(6, 1, 0, 0, "R8 high side on after re-command");
        step(8);

        // R2: mid enable, then re-enable
        en_lvl = 2'b01;
        expect_at(3, 0, 0, 0, "R2 mid enable forces both low");
        expect_at(8, 0, 0, 0, "R2 mid enable holds both low");
        step(9);
        en_lvl = 2'b10;
        expect_at(4, 1, 0, 0, "R2 re-enable restarts high side");
        step(6);
        en_lvl = 2'b00;
        expect_at(3, 0, 0, 0, "R2 low enable forces both low");
        step(5);
        en_lvl = 2'b10; pwm_lvl = 2'b00;
        expect_at(4, 0, 1, 0, "R2 re-enable restarts low side");
        step(6);

        // R1: supply drop while running
        supply_ok = 1'b0;
        expect_at(3, 0, 0, 0, "R1 supply drop forces both low");
        step(5);
        supply_ok = 1'b1;
        expect_at(4, 0, 1, 0, "R1 restart after supply returns");
        step(6);

        // R9: low-side feedback stuck, timeout to fault
        stuck_ls = 1'b1; pwm_lvl = 2'b10;
        expect_at(12, 0, 0, 0, "R9 still waiting before timeout");
        expect_at(13, 0, 0, 1, "R9 fault on timeout");
        step(14);
        stuck_ls = 1'b0;
        expect_at(5, 0, 0, 1, "R9 fault held while enabled");
        step(6);
        en_lvl = 2'b00;
        expect_at(3, 0, 0, 0, "R9 fault cleared by enable low");
        step(5);
        en_lvl = 2'b10;
        expect_at(4, 1, 0, 0, "R9 normal sequencing after clear");
        step(6);

        // R10: no cycle with both enables high
        n_chk++;
        if (n_overlap != 0) begin
            n_bad++;
            $display("FAIL R10 overlap cycles = %0d expected 0", n_overlap);
        end

        summary();
        $finish;
    end
endmodule